// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Table

This block keeps the reservations that make load-linked / store-conditional pairs atomic in a memory controller shared by several processors. A load-linked read records the word address in a small table of entries and hands back a key taken from a free-running counter. The requester later presents that address and key with its store-conditional. The controller first runs a check, which only tests the pair and leaves the reservation in place. It then sends a commit, which consumes the reservation just before the data is written. Ordinary writes name a byte range, and every reservation that falls inside that range is invalidated.

The four ports (load-linked, check, commit, plain write) are independent. Each takes a one-cycle request and answers with a registered acknowledge one cycle later. The load-linked and commit ports carry a 3-bit packet-type field. Only the matching command code acts on the table. The table itself is a bank of registers compared in parallel. When an address is not yet reserved, a load-linked takes the lowest-numbered free entry. When the table is full, it evicts an entry in round-robin order.

Top module: `llsc_resv_table`

## Requirements
- R1: After a synchronous reset, every entry is invalid, so any check fails. All acknowledges are low, and the first load-linked returns key 0.
- R2: The load-linked port acts only when `rd_pkt_type` equals 3'd6. A request with any other type produces no `rd_ack`, uses no key and leaves the table unchanged.
- R3: A load-linked request held over several cycles touches the table only in its first cycle. Each cycle of the request acknowledges with the same key. The request ends in the cycle where `rd_last` is high.
- R4: Keys come from a counter that advances by one on each load-linked that touches the table. Each such load-linked returns the counter value from before the increment.
- R5: A check returns `chk_ok`=1 only when a live entry holds the same word address (byte address shifted right by log2 of bytes per word) and the same key. The check never removes or changes an entry.
- R6: A commit with `sc_pkt_type` equal to 3'd3 that matches a live entry on address and key returns `sc_ok`=1 and removes that entry. A commit with any other type, or with no match, returns `sc_ok`=0 and changes nothing.
- R7: A plain write invalidates every live entry whose word address lies inclusively between `wr_addr` and `wr_addr + (wr_count << log2(bytes per word))`. Entries outside that range keep their state.
- R8: When a plain write and a check arrive in the same cycle, the check sees the table after the invalidation.
- R9: A load-linked to a word address that already holds a live entry overwrites that entry with the new key. The old key then fails, and no second entry is taken.
- R10: Otherwise a load-linked takes the lowest-numbered free entry. When no entry is free, it replaces entries in round-robin order starting from entry 0.
- R11: Every acknowledge (`rd_ack`, `chk_ack`, `sc_ack`, `wr_ack`) and its result are registered and appear exactly one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read-port request |
| rd_pkt_type | input | 3 | Packet-type field of the read command |
| rd_addr | input | ADDR_W | Byte address of the load-linked |
| rd_last | input | 1 | Final cycle of this read command |
| rd_ack | output | 1 | Load-linked acknowledge |
| rd_key | output | KEY_W | Reservation key returned |
| chk_req | input | 1 | Check request |
| chk_addr | input | ADDR_W | Byte address to test |
| chk_key | input | KEY_W | Key to test |
| chk_ack | output | 1 | Check acknowledge |
| chk_ok | output | 1 | Address and key match a live entry |
| sc_req | input | 1 | Commit request |
| sc_pkt_type | input | 3 | Packet-type field of the commit |
| sc_addr | input | ADDR_W | Byte address of the store-conditional |
| sc_key | input | KEY_W | Key presented |
| sc_ack | output | 1 | Commit acknowledge |
| sc_ok | output | 1 | A reservation was consumed |
| wr_req | input | 1 | Plain-write invalidation request |
| wr_addr | input | ADDR_W | First byte address written |
| wr_count | input | WCNT_W | Additional words beyond the first |
| wr_ack | output | 1 | Invalidation acknowledge |

## Verification
The bench builds the table with 4 entries, 16-bit keys, 4-byte words and a 4-bit word count. The small table fills after four reservations, so free-slot allocation, full-table replacement and the wrap of the round-robin pointer are all reached in a short run. The 4-byte word makes the shift in the range bound matter: a range that ends one word below a reservation, and a single-word write at the next word, both probe the inclusive limits.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  // command codes carried in the 3-bit packet-type field
  localparam logic [2:0] PT_LOAD_LINKED = 3'd6;
  localparam logic [2:0] PT_STORE_COND  = 3'd3;
endpackage

// File: rtl/llsc_cmp.sv
module llsc_cmp #(
  parameter int N     = 8,
  parameter int WA_W  = 30,
  parameter int KEY_W = 32
) (
  input  logic [N-1:0][WA_W-1:0]  ent_addr,
  input  logic [N-1:0][KEY_W-1:0] ent_key,
  input  logic [WA_W-1:0]         chk_w,
  input  logic [KEY_W-1:0]        chk_k,
  input  logic [WA_W-1:0]         sc_w,
  input  logic [KEY_W-1:0]        sc_k,
  input  logic [WA_W-1:0]         ll_w,
  input  logic [WA_W-1:0]         lo_w,
  input  logic [WA_W-1:0]         hi_w,
  output logic [N-1:0]            chk_eq,
  output logic [N-1:0]            sc_eq,
  output logic [N-1:0]            ll_eq,
  output logic [N-1:0]            in_rng
);
  // one comparator set per entry, all evaluated in parallel
  for (genvar e = 0; e < N; e++) begin : g_ent
    assign chk_eq[e] = (ent_addr[e] == chk_w) && (ent_key[e] == chk_k);
    assign sc_eq[e]  = (ent_addr[e] == sc_w)  && (ent_key[e] == sc_k);
    assign ll_eq[e]  = (ent_addr[e] == ll_w);
    assign in_rng[e] = (ent_addr[e] >= lo_w) && (ent_addr[e] <= hi_w);
  end
endmodule

// File: rtl/llsc_victim.sv
module llsc_victim #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     live,
  input  logic [N-1:0]     hit,
  input  logic [IDX_W-1:0] rr,
  output logic [IDX_W-1:0] sel,
  output logic             evict
);
  always_comb begin
    sel   = rr;
    evict = 1'b0;
    if (|hit) begin
      for (int i = N - 1; i >= 0; i--)
        if (hit[i]) sel = IDX_W'(i);
    end else if (!(&live)) begin
      for (int i = N - 1; i >= 0; i--)
        if (!live[i]) sel = IDX_W'(i);
    end else begin
      evict = 1'b1;
    end
  end
endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
  parameter int ADDR_W         = 32,
  parameter int KEY_W          = 32,
  parameter int ENTRIES        = 8,
  parameter int BYTES_PER_WORD = 4,
  parameter int WCNT_W         = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [2:0]        rd_pkt_type,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_last,
  output logic              rd_ack,
  output logic [KEY_W-1:0]  rd_key,
  input  logic              chk_req,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [KEY_W-1:0]  chk_key,
  output logic              chk_ack,
  output logic              chk_ok,
  input  logic              sc_req,
  input  logic [2:0]        sc_pkt_type,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic [KEY_W-1:0]  sc_key,
  output logic              sc_ack,
  output logic              sc_ok,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WCNT_W-1:0] wr_count,
  output logic              wr_ack
);
  import llsc_pkg::*;

  localparam int SHIFT = $clog2(BYTES_PER_WORD);
  localparam int WA_W  = ADDR_W - SHIFT;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  function automatic logic [WA_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return WA_W'(a >> SHIFT);
  endfunction

  // entry state
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][WA_W-1:0]   addr_q;
  logic [ENTRIES-1:0][KEY_W-1:0]  key_q;
  logic [KEY_W-1:0]               kcnt_q;
  logic [IDX_W-1:0]               rr_q;
  logic                           ll_done_q;

  // query words
  logic [WA_W-1:0] chk_w, sc_w, ll_w, lo_w, hi_w;
  assign chk_w = word_of(chk_addr);
  assign sc_w  = word_of(sc_addr);
  assign ll_w  = word_of(rd_addr);
  assign lo_w  = word_of(wr_addr);
  assign hi_w  = word_of(wr_addr + (ADDR_W'(wr_count) << SHIFT));

  logic [ENTRIES-1:0] chk_eq, sc_eq, ll_eq, in_rng;

  llsc_cmp #(.N(ENTRIES), .WA_W(WA_W), .KEY_W(KEY_W)) u_cmp (
    .ent_addr(addr_q), .ent_key(key_q),
    .chk_w(chk_w), .chk_k(chk_key),
    .sc_w(sc_w), .sc_k(sc_key),
    .ll_w(ll_w), .lo_w(lo_w), .hi_w(hi_w),
    .chk_eq(chk_eq), .sc_eq(sc_eq), .ll_eq(ll_eq), .in_rng(in_rng)
  );

  // same-cycle ordering: invalidate, then check/commit, then load-linked
  logic               ll_cmd, ll_touch, sc_cmd;
  logic [ENTRIES-1:0] kill, live1, chk_hit, sc_hit, live2, ll_hit, valid_d;
  logic [IDX_W-1:0]   vsel;
  logic               v_evict;

  llsc_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .live(live2), .hit(ll_hit), .rr(rr_q), .sel(vsel), .evict(v_evict)
  );

  always_comb begin
    ll_cmd   = rd_req && (rd_pkt_type == PT_LOAD_LINKED);
    ll_touch = ll_cmd && !ll_done_q;
    sc_cmd   = sc_req && (sc_pkt_type == PT_STORE_COND);
    kill     = wr_req ? in_rng : '0;
    live1    = valid_q & ~kill;
    chk_hit  = live1 & chk_eq;
    sc_hit   = sc_cmd ? (live1 & sc_eq) : '0;
    live2    = live1 & ~sc_hit;
    ll_hit   = live2 & ll_eq;
    valid_d  = live2;
    if (ll_touch) valid_d[vsel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= '0;
      kcnt_q    <= '0;
      rr_q      <= '0;
      ll_done_q <= 1'b0;
      rd_ack    <= 1'b0;
      rd_key    <= '0;
      chk_ack   <= 1'b0;
      chk_ok    <= 1'b0;
      sc_ack    <= 1'b0;
      sc_ok     <= 1'b0;
      wr_ack    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (ll_touch) begin
        kcnt_q <= kcnt_q + KEY_W'(1);
        rd_key <= kcnt_q;
      end
      if (ll_touch && v_evict)
        rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + IDX_W'(1);
      if (ll_cmd) ll_done_q <= !rd_last;
      rd_ack  <= ll_cmd;
      chk_ack <= chk_req;
      chk_ok  <= chk_req && (|chk_hit);
      sc_ack  <= sc_req;
      sc_ok   <= |sc_hit;
      wr_ack  <= wr_req;
    end
  end

  // payload storage, no reset
  always_ff @(posedge clk) begin
    if (ll_touch) begin
      addr_q[vsel] <= ll_w;
      key_q[vsel]  <= kcnt_q;
    end
  end

  // R3: a replayed load-linked leaves the key counter alone
  p_replay_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ll_cmd && ll_done_q) |=> (kcnt_q == $past(kcnt_q)));

  // R4: a touching load-linked returns the pre-increment counter value
  p_key_step_r4: assert property (@(posedge clk) disable iff (rst)
    ll_touch |=> (rd_key == $past(kcnt_q)) && (kcnt_q == $past(kcnt_q) + KEY_W'(1)));

  // R9: no two live entries ever share a word address
  p_addr_unique_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(valid_q & ll_eq));

  // R10: when not evicting and not overwriting, the chosen slot is free
  p_free_first_r10: assert property (@(posedge clk) disable iff (rst)
    (ll_touch && !(|ll_hit) && !v_evict) |-> !live2[vsel]);

  // R10: eviction happens only with a full table and uses the pointer
  p_evict_full_r10: assert property (@(posedge clk) disable iff (rst)
    (ll_touch && v_evict) |-> ((&live2) && (vsel == rr_q)));
endmodule

// File: tb/tb_llsc_resv_table.sv
`timescale 1ns/1ps
module tb_llsc_resv_table;
  import llsc_pkg::*;

  localparam int ADDR_W = 32;
  localparam int KEY_W  = 16;
  localparam int ENT    = 4;
  localparam int BPW    = 4;
  localparam int WCNT_W = 4;

  logic clk, rst;
  logic rd_req, rd_last, rd_ack;
  logic [2:0] rd_pkt_type, sc_pkt_type;
  logic [ADDR_W-1:0] rd_addr, chk_addr, sc_addr, wr_addr;
  logic [KEY_W-1:0] rd_key, chk_key, sc_key;
  logic chk_req, chk_ack, chk_ok, sc_req, sc_ack, sc_ok, wr_req, wr_ack;
  logic [WCNT_W-1:0] wr_count;

  llsc_resv_table #(.ADDR_W(ADDR_W), .KEY_W(KEY_W), .ENTRIES(ENT),
                    .BYTES_PER_WORD(BPW), .WCNT_W(WCNT_W)) dut (
    .clk(clk), .rst(rst),
    .rd_req(rd_req), .rd_pkt_type(rd_pkt_type), .rd_addr(rd_addr), .rd_last(rd_last),
    .rd_ack(rd_ack), .rd_key(rd_key),
    .chk_req(chk_req), .chk_addr(chk_addr), .chk_key(chk_key),
    .chk_ack(chk_ack), .chk_ok(chk_ok),
    .sc_req(sc_req), .sc_pkt_type(sc_pkt_type), .sc_addr(sc_addr), .sc_key(sc_key),
    .sc_ack(sc_ack), .sc_ok(sc_ok),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_count(wr_count), .wr_ack(wr_ack)
  );

  typedef struct { int due; logic [31:0] v; int req; } exp_t;
  exp_t q_rd[$], q_chk[$], q_sc[$], q_wr[$];

  int ncheck = 0, nfail = 0, cyc = 0;
  bit done = 0;
  int kc = 0;            // bench key counter model
  bit ll_busy = 0;
  int ll_held = 0;

  initial clk = 0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic fail_line(int req, string what, logic [31:0] act, logic [31:0] exp);
    nfail++;
    $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  task automatic judge(int req, string what, logic [31:0] act, exp_t e);
    ncheck++;
    if (e.due != cyc) fail_line(11, {what, " ack cycle"}, 32'(cyc), 32'(e.due));
    else if (act !== e.v) fail_line(req, what, act, e.v);
  endtask

  function automatic exp_t mk(logic [31:0] v, int req);
    exp_t e;
    e.due = cyc + 1; e.v = v; e.req = req;
    return e;
  endfunction

  // monitor: pops expected items as acknowledges appear
  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      if (rd_ack) begin
        if (q_rd.size() == 0) fail_line(2, "unexpected rd_ack", 1, 0);
        else begin e = q_rd.pop_front(); judge(e.req, "rd_key", 32'(rd_key), e); end
      end else if (q_rd.size() != 0 && q_rd[0].due <= cyc) begin
        e = q_rd.pop_front(); fail_line(11, "missing rd_ack", 0, 1);
      end
      if (chk_ack) begin
        if (q_chk.size() == 0) fail_line(11, "unexpected chk_ack", 1, 0);
        else begin e = q_chk.pop_front(); judge(e.req, "chk_ok", 32'(chk_ok), e); end
      end else if (q_chk.size() != 0 && q_chk[0].due <= cyc) begin
        e = q_chk.pop_front(); fail_line(11, "missing chk_ack", 0, 1);
      end
      if (sc_ack) begin
        if (q_sc.size() == 0) fail_line(11, "unexpected sc_ack", 1, 0);
        else begin e = q_sc.pop_front(); judge(e.req, "sc_ok", 32'(sc_ok), e); end
      end else if (q_sc.size() != 0 && q_sc[0].due <= cyc) begin
        e = q_sc.pop_front(); fail_line(11, "missing sc_ack", 0, 1);
      end
      if (wr_ack) begin
        if (q_wr.size() == 0) fail_line(11, "unexpected wr_ack", 1, 0);
        else begin e = q_wr.pop_front(); judge(e.req, "wr_ack", 32'(wr_ack), e); end
      end else if (q_wr.size() != 0 && q_wr[0].due <= cyc) begin
        e = q_wr.pop_front(); fail_line(11, "missing wr_ack", 0, 1);
      end
    end
  end

  // driver tasks: called right after a falling edge
  task automatic set_ll(logic [31:0] a, bit last, int req);
    int k;
    rd_req = 1; rd_pkt_type = PT_LOAD_LINKED; rd_addr = a; rd_last = last;
    if (!ll_busy) begin k = kc; kc++; ll_held = k; end
    else k = ll_held;
    ll_busy = !last;
    q_rd.push_back(mk(32'(k), req));
  endtask

  task automatic set_rd_other(logic [2:0] t, logic [31:0] a);
    rd_req = 1; rd_pkt_type = t; rd_addr = a; rd_last = 1;
  endtask

  task automatic set_chk(logic [31:0] a, int k, bit ok, int req);
    chk_req = 1; chk_addr = a; chk_key = KEY_W'(k);
    q_chk.push_back(mk(32'(ok), req));
  endtask

  task automatic set_sc(logic [2:0] t, logic [31:0] a, int k, bit ok, int req);
    sc_req = 1; sc_pkt_type = t; sc_addr = a; sc_key = KEY_W'(k);
    q_sc.push_back(mk(32'(ok), req));
  endtask

  task automatic set_wr(logic [31:0] a, int c, int req);
    wr_req = 1; wr_addr = a; wr_count = WCNT_W'(c);
    q_wr.push_back(mk(32'd1, req));
  endtask

  task automatic cyc_end();
    @(negedge clk);
    rd_req = 0; chk_req = 0; sc_req = 0; wr_req = 0;
  endtask

  task automatic chk1(logic [31:0] a, int k, bit ok, int req);
    set_chk(a, k, ok, req); cyc_end();
  endtask

  initial begin
    rst = 1; rd_req = 0; rd_pkt_type = 0; rd_addr = 0; rd_last = 0;
    chk_req = 0; chk_addr = 0; chk_key = 0;
    sc_req = 0; sc_pkt_type = 0; sc_addr = 0; sc_key = 0;
    wr_req = 0; wr_addr = 0; wr_count = 0;
    repeat (3) @(negedge clk);
    // R1: reset state of the acknowledges
    ncheck++;
    if ({rd_ack, chk_ack, sc_ack, wr_ack} !== 4'b0)
      fail_line(1, "acks after reset", 32'({rd_ack, chk_ack, sc_ack, wr_ack}), 0);
    rst = 0;
    chk1(32'h100, 0, 0, 1);                 // R1: empty table
    set_ll(32'h100, 1, 1); cyc_end();       // R1/R4: first key is 0
    chk1(32'h100, 0, 1, 5);                 // R5 match
    chk1(32'h100, 0, 1, 5);                 // R5 not consumed
    chk1(32'h100, 5, 0, 5);                 // R5 wrong key
    chk1(32'h104, 0, 0, 5);                 // R5 wrong word
    chk1(32'h102, 0, 1, 5);                 // R5 same word, other byte
    // R2: other packet type is ignored: no ack, no key consumed
    set_rd_other(3'd0, 32'h200); cyc_end();
    set_rd_other(PT_STORE_COND, 32'h200); cyc_end();
    chk1(32'h200, 1, 0, 2);
    // R3: held request returns one key; R4: next key continues
    set_ll(32'h200, 0, 3); cyc_end();
    set_ll(32'h200, 0, 3); cyc_end();
    set_ll(32'h200, 1, 3); cyc_end();
    set_ll(32'h300, 1, 4); cyc_end();
    chk1(32'h200, 1, 1, 3);
    chk1(32'h300, 2, 1, 4);
    // R6: wrong type does nothing, right type consumes once
    set_sc(3'd0, 32'h200, 1, 0, 6); cyc_end();
    chk1(32'h200, 1, 1, 6);
    set_sc(PT_STORE_COND, 32'h200, 1, 1, 6); cyc_end();
    chk1(32'h200, 1, 0, 6);
    set_sc(PT_STORE_COND, 32'h200, 1, 0, 6); cyc_end();
    set_sc(PT_STORE_COND, 32'h300, 9, 0, 6); cyc_end();
    chk1(32'h300, 2, 1, 6);
    // R7: range invalidation, inclusive upper bound
    set_ll(32'h400, 1, 10); cyc_end();      // key 3 into freed slot
    set_wr(32'h2F8, 2, 7); cyc_end();       // covers 0x2F8..0x300
    chk1(32'h300, 2, 0, 7);
    chk1(32'h100, 0, 1, 7);
    chk1(32'h400, 3, 1, 7);
    set_wr(32'h0F0, 3, 7); cyc_end();       // ends at 0x0FC
    chk1(32'h100, 0, 1, 7);
    set_wr(32'h104, 0, 7); cyc_end();       // single next word
    chk1(32'h100, 0, 1, 7);
    // R8: same-cycle invalidation and check
    set_wr(32'h100, 0, 8); set_chk(32'h100, 0, 0, 8); cyc_end();
    chk1(32'h100, 0, 0, 8);
    // R9: overwrite of a live address
    set_ll(32'h400, 1, 9); cyc_end();       // key 4
    chk1(32'h400, 3, 0, 9);
    chk1(32'h400, 4, 1, 9);
    // R10: fill free slots, then round-robin eviction
    set_ll(32'hA00, 1, 10); cyc_end();      // key 5 slot 0
    set_ll(32'hB00, 1, 10); cyc_end();      // key 6 slot 2
    set_ll(32'hC00, 1, 10); cyc_end();      // key 7 slot 3
    chk1(32'h400, 4, 1, 9);                 // R9: no extra slot was taken
    set_ll(32'hD00, 1, 10); cyc_end();      // key 8 evicts slot 0
    chk1(32'hA00, 5, 0, 10);
    chk1(32'h400, 4, 1, 10);
    set_ll(32'hE00, 1, 10); cyc_end();      // key 9 evicts slot 1
    chk1(32'h400, 4, 0, 10);
    chk1(32'hB00, 6, 1, 10);
    chk1(32'hC00, 7, 1, 10);
    chk1(32'hD00, 8, 1, 10);
    chk1(32'hE00, 9, 1, 10);
    repeat (3) @(negedge clk);
    // R11: nothing left unanswered
    ncheck++;
    if (q_rd.size() + q_chk.size() + q_sc.size() + q_wr.size() != 0)
      fail_line(11, "pending acks", 32'(q_rd.size() + q_chk.size() + q_sc.size() + q_wr.size()), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", ncheck, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      ncheck++;
      fail_line(11, "watchdog expired", 32'(cyc), 0);
      $display("[TB] %0d tests run, %0d failed", ncheck, nfail);
      $finish;
    end
  end
endmodule